// File: doc/BRIEF.md
# Multi-Mode Event Timer

This block is a general-purpose 16-bit timer. It has one input pin and one output pin. A power-of-two prescaler sets how often the counter advances. A mode field selects one of five behaviours:

- pulse-width output
- input capture
- toggling compare output
- level-gated counting
- capture/compare that waits for a start edge

A single polarity bit controls each mode, and its meaning depends on the mode. It sets the output level, the active capture edge, the gate level or the start edge. The block raises a one-clock interrupt pulse for every reload or input event it reports.

The configuration inputs come from register logic outside the block. Software writes the reload and PWM values, the mode, the polarity and the prescale field, then sets the enable bit. While the enable bit is low, the block is idle and its output shows the polarity bit. When the enable bit rises, counting restarts from a known state. The timer input is asynchronous and is synchronised inside the block.

Top module: `mm_timer`

## Requirements
- R1: The counter advances once every 2^div_sel clocks while the timer is enabled. The field div_sel runs from 0 to 7. The mode codes are 0 for PWM, 1 for capture, 2 for compare, 3 for gated and 4 for capture/compare. Codes 5 to 7 behave as compare.
- R2: While en is low, the prescaler is cleared and the count reads 1. After en rises, the first advance comes after a full 2^div_sel clocks.
- R3: When a counter advance finds the count equal to reload_val, the count returns to 1, and irq is high for the one clock that follows.
- R4: While en is low, tmr_out takes the value of pol one clock later, and irq stays low.
- R5: In PWM mode, tmr_out goes to the inverse of pol on an advance that finds the count equal to pwm_val. It goes back to pol on reload.
- R6: In compare mode, tmr_out toggles on every reload. Changing pol while the timer runs leaves tmr_out unchanged until the next reload toggle.
- R7: In capture mode, a rising input edge (pol=0) or a falling input edge (pol=1) copies the count into cap_val and pulses irq. The other edge does neither, and the counter keeps running in both cases.
- R8: In gated mode, the counter advances only while the input is high (pol=0) or low (pol=1). The edge that ends the active level pulses irq, and the edge that starts it does not.
- R9: In capture/compare mode, the count stays at 1 until the first active edge: rising for pol=0, falling for pol=1. Each later active edge copies the count into cap_val and pulses irq, without stopping the counter. The opposite edge is ignored.
- R10: A change on tmr_in first takes effect at the third rising clock edge after it.
- R11: A capture edge and a reload in the same clock give a single irq pulse. In that clock, cap_val receives the reload value and the count returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Timer enable |
| mode | input | 3 | Mode select (codes in R1) |
| pol | input | 1 | Polarity, meaning depends on the mode |
| div_sel | input | 3 | Prescale exponent |
| reload_val | input | 16 | Count value that triggers reload |
| pwm_val | input | 16 | Count value that flips the PWM output |
| tmr_in | input | 1 | Asynchronous timer input |
| tmr_out | output | 1 | Timer output |
| irq | output | 1 | One-clock interrupt pulse |
| cap_val | output | 16 | Captured count |
| count | output | 16 | Current count |

## Verification
In capture/compare mode, an active input edge and a counter reload can arrive in the same clock. Both want to drive the interrupt, and the capture samples a count that is just being reset.

To provoke this, the bench arms the timer and counts clocks until the count is two below the reload value. It then toggles the input, so that after the three-edge synchroniser latency the capture lands exactly on the reload edge.

The check passes only if all three of these hold:
- exactly one interrupt pulse appears;
- the capture register holds the reload value;
- the count reads 1.

// File: rtl/mm_timer.sv
module mm_timer #(
  parameter int CW = 16,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    mode,
  input  logic          pol,
  input  logic [PW-1:0] div_sel,
  input  logic [CW-1:0] reload_val,
  input  logic [CW-1:0] pwm_val,
  input  logic          tmr_in,
  output logic          tmr_out,
  output logic          irq,
  output logic [CW-1:0] cap_val,
  output logic [CW-1:0] count
);
  localparam int PCW = (1 << PW) - 1;
  localparam logic [PCW-1:0] P_ONE = {{(PCW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0]  C_ONE = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [2:0] M_PWM = 3'd0, M_CAP = 3'd1, M_GATE = 3'd3, M_CC = 3'd4;

  logic [PCW-1:0] pcnt, pmask;
  logic [PCW:0]   pstep;
  logic [2:0]     sy;
  logic           armed;

  assign pstep = {{PCW{1'b0}}, 1'b1} << div_sel;
  assign pmask = pstep[PCW-1:0] - P_ONE;
  wire tick = en && ((pcnt & pmask) == pmask);

  wire lvl      = sy[1];
  wire rise     = sy[1] & ~sy[2];
  wire fall     = ~sy[1] & sy[2];
  wire act_edge = pol ? fall : rise;
  wire gate_end = pol ? rise : fall;

  wire is_pwm  = (mode == M_PWM);
  wire is_cap  = (mode == M_CAP);
  wire is_gate = (mode == M_GATE);
  wire is_cc   = (mode == M_CC);
  wire is_cmp  = !(is_pwm || is_cap || is_gate || is_cc);

  wire run    = tick && (is_gate ? (lvl != pol) : (is_cc ? armed : 1'b1));
  wire rl     = run && (count == reload_val);
  wire pmatch = run && (count == pwm_val);
  wire cap_ev = en && act_edge && (is_cap || (is_cc && armed));
  wire gte_ev = en && is_gate && gate_end;
  wire arm_ev = en && is_cc && !armed && act_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy      <= '0;
      pcnt    <= '0;
      count   <= C_ONE;
      armed   <= 1'b0;
      irq     <= 1'b0;
      tmr_out <= 1'b0;
      cap_val <= '0;
    end else begin
      sy <= {sy[1:0], tmr_in};
      if (!en) begin
        pcnt    <= '0;
        count   <= C_ONE;
        armed   <= 1'b0;
        irq     <= 1'b0;
        tmr_out <= pol;
      end else begin
        pcnt <= pcnt + P_ONE;
        if (rl)       count <= C_ONE;
        else if (run) count <= count + C_ONE;
        if (arm_ev)   armed <= 1'b1;
        irq <= rl | cap_ev | gte_ev;
        if (is_pwm) begin
          if (rl)          tmr_out <= pol;
          else if (pmatch) tmr_out <= ~pol;
        end else if ((is_cmp || is_cc) && rl) begin
          tmr_out <= ~tmr_out;
        end
      end
      if (cap_ev) cap_val <= count;
    end
  end
endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          pol,
  input logic          tmr_out,
  input logic          irq,
  input logic [CW-1:0] cap_val,
  input logic [CW-1:0] count
);
  localparam logic [CW-1:0] C_ONE = {{(CW-1){1'b0}}, 1'b1};

  a_r4_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tmr_out == $past(pol)));

  a_r4_idle_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq);

  a_r2_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count == C_ONE));

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (count == $past(count) || count == $past(count) + C_ONE || count == C_ONE));

  a_r7_cap_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_val != $past(cap_val)) |-> irq);
endmodule

bind mm_timer mm_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .tmr_out(tmr_out),
  .irq(irq), .cap_val(cap_val), .count(count)
);

// File: tb/tb_mm_timer.sv
`timescale 1ns/1ps
module tb_mm_timer;
  localparam logic [2:0] M_PWM = 3'd0, M_CAP = 3'd1, M_CMP = 3'd2, M_GATE = 3'd3, M_CC = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  mode = M_CMP;
  logic        pol = 1'b0;
  logic [2:0]  div_sel = 3'd0;
  logic [15:0] reload_val = 16'd1000;
  logic [15:0] pwm_val = 16'd0;
  logic        tmr_in = 1'b0;
  logic        tmr_out, irq;
  logic [15:0] cap_val, count;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mm_timer dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .pol(pol), .div_sel(div_sel),
    .reload_val(reload_val), .pwm_val(pwm_val), .tmr_in(tmr_in),
    .tmr_out(tmr_out), .irq(irq), .cap_val(cap_val), .count(count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic step_irq(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) pulses++;
    end
  endtask

  task automatic setup(input logic [2:0] m, input logic p, input logic [2:0] d,
                       input logic [15:0] rv, input logic [15:0] pv);
    en = 1'b0;
    mode = m; pol = p; div_sel = d; reload_val = rv; pwm_val = pv;
    step(4);
  endtask

  task automatic t_reset();
    chk("R4 reset out", tmr_out, 0);
    chk("R4 reset irq", irq, 0);
    chk("R2 reset count", count, 1);
    chk("R7 reset cap", cap_val, 0);
  endtask

  task automatic t_prescale();
    setup(M_CMP, 1'b0, 3'd2, 16'd1000, 16'd0);
    en = 1'b1; step(8);
    chk("R1 div4 count", count, 3);
    en = 1'b0; step(1); div_sel = 3'd0; en = 1'b1; step(5);
    chk("R1 div1 count", count, 6);
    en = 1'b0; step(1); div_sel = 3'd7; en = 1'b1; step(127);
    chk("R1 div128 before", count, 1);
    step(1);
    chk("R1 div128 after", count, 2);
  endtask

  task automatic t_clear();
    setup(M_CMP, 1'b0, 3'd2, 16'd1000, 16'd0);
    en = 1'b1; step(6);
    chk("R2 running", count, 2);
    en = 1'b0; step(1);
    chk("R2 idle count", count, 1);
    en = 1'b1; step(3);
    chk("R2 restart early", count, 1);
    step(1);
    chk("R2 restart full", count, 2);
  endtask

  task automatic t_reload();
    int p;
    setup(M_CMP, 1'b0, 3'd0, 16'd5, 16'd0);
    en = 1'b1; step(4);
    chk("R3 top count", count, 5);
    chk("R3 no irq before", irq, 0);
    step(1);
    chk("R3 wrap count", count, 1);
    chk("R3 irq pulse", irq, 1);
    step(1);
    chk("R3 irq one clock", irq, 0);
    step_irq(20, p);
    chk("R3 pulse rate", p, 4);
  endtask

  task automatic t_idle();
    setup(M_PWM, 1'b1, 3'd0, 16'd10, 16'd3);
    chk("R4 idle out pol1", tmr_out, 1);
    pol = 1'b0; step(1);
    chk("R4 idle out pol0", tmr_out, 0);
    chk("R4 idle irq", irq, 0);
  endtask

  task automatic t_compare();
    setup(M_CMP, 1'b1, 3'd0, 16'd4, 16'd0);
    chk("R6 idle level", tmr_out, 1);
    en = 1'b1; step(3);
    chk("R6 before reload", tmr_out, 1);
    step(1);
    chk("R6 first toggle", tmr_out, 0);
    step(4);
    chk("R6 second toggle", tmr_out, 1);
    pol = 1'b0; step(1);
    chk("R6 pol change held", tmr_out, 1);
    step(2);
    chk("R6 pol change held late", tmr_out, 1);
    step(1);
    chk("R6 third toggle", tmr_out, 0);
    mode = 3'd6; step(4);
    chk("R1 reserved code as compare", tmr_out, 1);
  endtask

  task automatic t_pwm();
    setup(M_PWM, 1'b1, 3'd0, 16'd8, 16'd3);
    chk("R5 idle high", tmr_out, 1);
    en = 1'b1; step(2);
    chk("R5 before match", tmr_out, 1);
    step(1);
    chk("R5 match low", tmr_out, 0);
    step(4);
    chk("R5 hold low", tmr_out, 0);
    step(1);
    chk("R5 reload high", tmr_out, 1);
    step(3);
    chk("R5 second match", tmr_out, 0);
    setup(M_PWM, 1'b0, 3'd0, 16'd8, 16'd3);
    chk("R5 inv idle low", tmr_out, 0);
    en = 1'b1; step(3);
    chk("R5 inv match high", tmr_out, 1);
    step(5);
    chk("R5 inv reload low", tmr_out, 0);
  endtask

  task automatic t_capture();
    int p;
    tmr_in = 1'b0;
    setup(M_CAP, 1'b0, 3'd0, 16'd1000, 16'd0);
    en = 1'b1; step(9);
    chk("R7 count before", count, 10);
    tmr_in = 1'b1; step(2);
    chk("R10 no early irq", irq, 0);
    chk("R10 no early capture", cap_val, 0);
    step(1);
    chk("R7 rise irq", irq, 1);
    chk("R7 rise captured", cap_val, 12);
    chk("R7 counter runs", count, 13);
    tmr_in = 1'b0; step_irq(5, p);
    chk("R7 fall ignored irq", p, 0);
    chk("R7 fall ignored cap", cap_val, 12);
    setup(M_CAP, 1'b1, 3'd0, 16'd1000, 16'd0);
    en = 1'b1; step(4);
    tmr_in = 1'b1; step_irq(6, p);
    chk("R7 pol1 rise ignored", p, 0);
    chk("R7 pol1 cap held", cap_val, 12);
    tmr_in = 1'b0; step(3);
    chk("R7 pol1 fall irq", irq, 1);
    chk("R7 pol1 fall captured", cap_val, 13);
  endtask

  task automatic t_gated();
    int p;
    tmr_in = 1'b0;
    setup(M_GATE, 1'b0, 3'd0, 16'd1000, 16'd0);
    en = 1'b1; step(5);
    chk("R8 gate closed", count, 1);
    tmr_in = 1'b1; step_irq(7, p);
    chk("R8 counts when high", count, 6);
    chk("R8 start edge silent", p, 0);
    tmr_in = 1'b0; step_irq(4, p);
    chk("R8 stops after fall", count, 8);
    chk("R8 fall irq", p, 1);
    setup(M_GATE, 1'b1, 3'd0, 16'd1000, 16'd0);
    en = 1'b1; step(3);
    chk("R8 pol1 counts low", count, 4);
    tmr_in = 1'b1; step_irq(4, p);
    chk("R8 pol1 stops", count, 6);
    chk("R8 pol1 rise irq", p, 1);
  endtask

  task automatic t_capcmp();
    int p;
    tmr_in = 1'b0;
    setup(M_CC, 1'b0, 3'd0, 16'd1000, 16'd0);
    en = 1'b1; step(6);
    chk("R9 waits for start", count, 1);
    tmr_in = 1'b1; step_irq(3, p);
    chk("R9 arm edge", count, 1);
    chk("R9 arm no irq", p, 0);
    step(2);
    chk("R9 counting", count, 3);
    tmr_in = 1'b0; step_irq(4, p);
    chk("R9 fall ignored", p, 0);
    chk("R9 count after fall", count, 7);
    tmr_in = 1'b1; step(3);
    chk("R9 capture irq", irq, 1);
    chk("R9 captured", cap_val, 9);
    chk("R9 still running", count, 10);
  endtask

  task automatic t_coincide();
    int p;
    tmr_in = 1'b0;
    setup(M_CC, 1'b0, 3'd0, 16'd20, 16'd0);
    en = 1'b1; tmr_in = 1'b1; step(3);
    tmr_in = 1'b0; step(17);
    chk("R11 lead count", count, 18);
    tmr_in = 1'b1; step(2);
    chk("R11 no early irq", irq, 0);
    step(1);
    chk("R11 single irq", irq, 1);
    chk("R11 cap reload", cap_val, 20);
    chk("R11 count wrapped", count, 1);
    step_irq(3, p);
    chk("R11 pulse ends", p, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_prescale();
    t_clear();
    t_reload();
    t_idle();
    t_compare();
    t_pwm();
    t_capture();
    t_gated();
    t_capcmp();
    t_coincide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule